// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the bus side of a small sensor-style peripheral on an I2C/SMBus two-wire bus. It watches oversampled SCL and SDA lines and decodes START, STOP and repeated START conditions. It pulls SDA low through an output-enable whenever it acknowledges or shifts out a zero. Its 7-bit address is the fixed prefix `1001` followed by three strap pins. The strap value is captured at every START and on a general-call re-latch, and is held in between.

Four 16-bit registers sit outside the block behind a byte-wide write strobe and a 16-bit read bus. The byte that follows a write address is a pointer, and its two low bits select the register. Later bytes in the same write go into that register, most significant byte first. A read always starts from the last pointer written and returns the high byte, then the low byte.

The block also handles several special bus cases. It answers the general call with a re-latch command or a reset command. It answers the SMBus alert-response address while an alert is pending, and it arbitrates while it sends its reply. It tracks the high-speed master code. It also drops the transaction if either line stays low for too long.

Top module: `ptr_reg_i2c_slave`

## Requirements
- R1: A write or read address byte whose upper 7 bits equal {1001, strap[2:0]} is acknowledged, meaning SDA is held low during the ninth clock. Any other ordinary address is not acknowledged.
- R2: The first byte after an acknowledged write address loads bits [1:0] into the pointer on `reg_addr`. Pointer code 00 is the read-only temperature register, 01 is configuration, 10 is the low limit and 11 is the high limit. A write carrying only the pointer is legal. The pointer keeps its value across transactions and resets to 00.
- R3: After an acknowledged read address, the slave shifts out `reg_rdata[15:8]` and then `reg_rdata[7:0]` for the current pointer, MSB first.
- R4: Each data byte after the pointer pulses `reg_wr` for one cycle with `reg_wdata` set to the byte. `reg_wr_msb` is 1 for the first, third and later odd bytes, and 0 for the others. No strobe is issued while the pointer is 00.
- R5: A NACK from the master after a read byte ends the transfer. The slave drives nothing until the next START.
- R6: The general call (first byte 0x00) is acknowledged. A command byte of 0x04 re-latches the strap pins only. A command byte of 0x06 re-latches the straps, pulses `gc_reset` and returns the pointer to 00.
- R7: The alert-response byte 0x19 is acknowledged only while `alert_active` is 1. The reply byte is {1001, strap[2:0], alert_high}.
- R8: During that reply, if SDA reads low while the slave is sending a 1, the slave stops driving and does not clear the alert. A reply sent to the end pulses `alert_clr` once, at the following STOP or START.
- R9: A first byte of the form 00001xxx is not acknowledged. It sets `hs_mode`, which stays set across repeated STARTs until a STOP.
- R10: Between a START and a STOP, if SCL or SDA stays low for TIMEOUT_CYC clocks, the slave releases SDA and ignores the bus until a new START.
- R11: A strap change after a START does not affect address matching for that transaction. `sda_oe` changes only while the synchronized SCL is low, except on a time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Address strap pins, low address bits |
| reg_addr | output | 2 | Current pointer, selects the register |
| reg_rdata | input | 16 | Contents of the selected register |
| reg_wr | output | 1 | One-cycle write strobe per data byte |
| reg_wr_msb | output | 1 | 1 when the strobed byte is a high byte |
| reg_wdata | output | 8 | Byte to write |
| alert_active | input | 1 | Alert pending in the register side |
| alert_high | input | 1 | 1 if the pending alert is a high-limit alert |
| alert_clr | output | 1 | One-cycle pulse after a won alert response |
| gc_reset | output | 1 | One-cycle pulse to reset the register bank |
| hs_mode | output | 1 | High-speed master code seen since last STOP |

## Verification
The bench checks that the pointer survives a pointer-only write and a later separate read. A design that cleared the pointer at STOP would return the temperature register instead. It writes to pointer 00 and confirms the temperature value is unchanged, which catches a missing write guard. It makes the master NACK and then keep clocking; a slave that kept driving the low byte would read back as something other than 0xFF. The bench also forces a lost arbitration in the alert response, where a wrong design would pull `alert_clr` anyway. It holds SCL low past the time-out with the slave driving a zero, then shows that the slave has let go and still answers a fresh START.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_ACK_SET, ST_ACK_HOLD,
    ST_TX, ST_TX_REL, ST_MACK, ST_TX_LOAD
  } st_t;

  typedef enum logic [1:0] {M_WR, M_RD, M_GC, M_ARA} mode_t;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RELATCH   = 8'h04;
  localparam logic [7:0] GC_RESET     = 8'h06;
  localparam logic [7:0] ARA_BYTE     = 8'h19;
  localparam logic [4:0] HS_PREFIX    = 5'b00001;
endpackage

// File: rtl/i2cps_sync.sv
module i2cps_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 2'b11;
      sync_q <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      meta_q <= {scl_i, sda_i};
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign scl_s     = sync_q[1];
  assign sda_s     = sync_q[0];
  assign scl_rise  = sync_q[1] & ~prev_q[1];
  assign scl_fall  = ~sync_q[1] & prev_q[1];
  assign start_det = sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
  assign stop_det  = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];
endmodule

// File: rtl/i2cps_tmo.sv
module i2cps_tmo #(
  parameter int unsigned LIMIT = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic [1:0] lines,
  output logic       tmo
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [1:0] hit;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = cnt_q;
        if (!armed || lines[g])          cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))    cnt_d = cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign hit[g] = armed && (cnt_q == CW'(LIMIT));
    end
  endgenerate

  assign tmo = |hit;
endmodule

// File: rtl/i2cps_core.sv
module i2cps_core
  import i2cps_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        tmo,
  input  logic [2:0]  strap,
  input  logic [15:0] reg_rdata,
  input  logic        alert_active,
  input  logic        alert_high,
  output logic        sda_oe,
  output logic        busy,
  output logic        hs_mode,
  output logic [1:0]  reg_addr,
  output logic        reg_wr,
  output logic        reg_wr_msb,
  output logic [7:0]  reg_wdata,
  output logic        alert_clr,
  output logic        gc_reset
);
  st_t        state_q, state_d;
  mode_t      mode_q, mode_d;
  logic [2:0] bitcnt_q, bitcnt_d, dev_lo_q, dev_lo_d;
  logic [7:0] sh_q, sh_d, wdata_q, wdata_d;
  logic [1:0] ptr_q, ptr_d;
  logic       oe_q, oe_d, busy_q, busy_d, hs_q, hs_d;
  logic       first_q, first_d, msb_q, msb_d, won_q, won_d;
  logic       wr_q, wr_d, wmsb_q, wmsb_d, clr_q, clr_d, gcr_q, gcr_d;
  logic [7:0] rx_byte, load_byte;

  assign rx_byte   = {sh_q[6:0], sda_s};
  assign load_byte = (mode_q == M_ARA) ? {ADDR_PREFIX, dev_lo_q, alert_high}
                   : (msb_q ? reg_rdata[15:8] : reg_rdata[7:0]);

  always_comb begin
    state_d = state_q;  mode_d = mode_q;   bitcnt_d = bitcnt_q;
    dev_lo_d = dev_lo_q; sh_d = sh_q;      wdata_d = wdata_q;
    ptr_d = ptr_q;      oe_d = oe_q;       busy_d = busy_q;
    hs_d = hs_q;        first_d = first_q; msb_d = msb_q;
    won_d = won_q;      wmsb_d = wmsb_q;
    wr_d = 1'b0;        clr_d = 1'b0;      gcr_d = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR; bitcnt_d = '0; dev_lo_d = strap; oe_d = 1'b0;
      busy_d = 1'b1; clr_d = won_q; won_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE; oe_d = 1'b0; busy_d = 1'b0; hs_d = 1'b0;
      clr_d = won_q; won_d = 1'b0;
    end else if (tmo) begin
      state_d = ST_IDLE; oe_d = 1'b0; busy_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_d = rx_byte; bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == 3'd7) begin
            first_d = 1'b1; msb_d = 1'b1; state_d = ST_IDLE;
            if (rx_byte[7:1] == {ADDR_PREFIX, dev_lo_q}) begin
              mode_d = rx_byte[0] ? M_RD : M_WR; state_d = ST_ACK_SET;
            end else if (rx_byte == GC_ADDR_BYTE) begin
              mode_d = M_GC; state_d = ST_ACK_SET;
            end else if (rx_byte == ARA_BYTE && alert_active) begin
              mode_d = M_ARA; state_d = ST_ACK_SET;
            end else if (rx_byte[7:3] == HS_PREFIX) begin
              hs_d = 1'b1;
            end
          end
        end
        ST_RX: if (scl_rise) begin
          sh_d = rx_byte; bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == 3'd7) begin
            state_d = ST_ACK_SET;
            if (mode_q == M_GC) begin
              if (rx_byte == GC_RELATCH) dev_lo_d = strap;
              if (rx_byte == GC_RESET) begin
                dev_lo_d = strap; gcr_d = 1'b1; ptr_d = '0;
              end
            end else if (first_q) begin
              ptr_d = rx_byte[1:0]; first_d = 1'b0;
            end else if (ptr_q != 2'd0) begin
              wr_d = 1'b1; wmsb_d = msb_q; wdata_d = rx_byte; msb_d = ~msb_q;
            end
          end
        end
        ST_ACK_SET: if (scl_fall) begin
          oe_d = 1'b1; state_d = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          bitcnt_d = '0;
          if (mode_q == M_RD || mode_q == M_ARA) begin
            sh_d = load_byte; oe_d = ~load_byte[7]; msb_d = ~msb_q; state_d = ST_TX;
          end else begin
            oe_d = 1'b0; state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 1'b1;
            if (mode_q == M_ARA && !oe_q && !sda_s) begin
              state_d = ST_IDLE;
            end else if (bitcnt_q == 3'd7) begin
              state_d = ST_TX_REL;
              if (mode_q == M_ARA) won_d = 1'b1;
            end
          end
          if (scl_fall) begin
            sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
          end
        end
        ST_TX_REL: if (scl_fall) begin
          oe_d = 1'b0; state_d = ST_MACK;
        end
        ST_MACK: if (scl_rise) begin
          state_d = (sda_s || mode_q == M_ARA) ? ST_IDLE : ST_TX_LOAD;
        end
        ST_TX_LOAD: if (scl_fall) begin
          sh_d = load_byte; oe_d = ~load_byte[7]; msb_d = ~msb_q;
          bitcnt_d = '0; state_d = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; mode_q <= M_WR; bitcnt_q <= '0; dev_lo_q <= '0;
      sh_q <= '0; wdata_q <= '0; ptr_q <= '0; oe_q <= 1'b0; busy_q <= 1'b0;
      hs_q <= 1'b0; first_q <= 1'b0; msb_q <= 1'b1; won_q <= 1'b0;
      wr_q <= 1'b0; wmsb_q <= 1'b0; clr_q <= 1'b0; gcr_q <= 1'b0;
    end else begin
      state_q <= state_d; mode_q <= mode_d; bitcnt_q <= bitcnt_d; dev_lo_q <= dev_lo_d;
      sh_q <= sh_d; wdata_q <= wdata_d; ptr_q <= ptr_d; oe_q <= oe_d; busy_q <= busy_d;
      hs_q <= hs_d; first_q <= first_d; msb_q <= msb_d; won_q <= won_d;
      wr_q <= wr_d; wmsb_q <= wmsb_d; clr_q <= clr_d; gcr_q <= gcr_d;
    end
  end

  assign sda_oe     = oe_q;
  assign busy       = busy_q;
  assign hs_mode    = hs_q;
  assign reg_addr   = ptr_q;
  assign reg_wr     = wr_q;
  assign reg_wr_msb = wmsb_q;
  assign reg_wdata  = wdata_q;
  assign alert_clr  = clr_q;
  assign gc_reset   = gcr_q;
endmodule

// File: rtl/ptr_reg_i2c_slave.sv
module ptr_reg_i2c_slave #(
  parameter int unsigned TIMEOUT_CYC = 4000,
  parameter logic [3:0]  ADDR_PREFIX = 4'b1001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  strap,
  output logic [1:0]  reg_addr,
  input  logic [15:0] reg_rdata,
  output logic        reg_wr,
  output logic        reg_wr_msb,
  output logic [7:0]  reg_wdata,
  input  logic        alert_active,
  input  logic        alert_high,
  output logic        alert_clr,
  output logic        gc_reset,
  output logic        hs_mode
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, tmo, busy;

  i2cps_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cps_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .armed(busy), .lines({scl_s, sda_s}), .tmo(tmo)
  );

  i2cps_core #(.ADDR_PREFIX(ADDR_PREFIX)) u_core (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tmo(tmo), .strap(strap),
    .reg_rdata(reg_rdata), .alert_active(alert_active), .alert_high(alert_high),
    .sda_oe(sda_oe), .busy(busy), .hs_mode(hs_mode), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wr_msb(reg_wr_msb), .reg_wdata(reg_wdata),
    .alert_clr(alert_clr), .gc_reset(gc_reset)
  );
endmodule

// File: rtl/i2cps_chk.sv
module i2cps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       stop_det,
  input logic       tmo,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       alert_clr,
  input logic       gc_reset,
  input logic       hs_mode
);
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(tmo)));

  assert_no_temp_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr != 2'd0));

  assert_gc_ptr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |-> (reg_addr == 2'd0));

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |=> !alert_clr);

  assert_hs_drop_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);

  assert_tmo_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !sda_oe);
endmodule

bind ptr_reg_i2c_slave i2cps_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .stop_det(stop_det),
  .tmo(tmo), .reg_wr(reg_wr), .reg_addr(reg_addr), .alert_clr(alert_clr),
  .gc_reset(gc_reset), .hs_mode(hs_mode)
);

// File: tb/ptr_reg_i2c_slave_tb.sv
`timescale 1ns/1ps
module ptr_reg_i2c_slave_tb;
  localparam int H = 16;
  localparam int TMO = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mscl = 1'b1, msda = 1'b1;
  logic [2:0] strap = 3'd0;
  logic alert_active = 1'b0, alert_high = 1'b0;
  logic sda_oe, reg_wr, reg_wr_msb, alert_clr, gc_reset, hs_mode;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] mem [4];
  wire  sda_line = msda & ~sda_oe;
  int nvec = 0, nfail = 0, wr_cnt = 0, gc_cnt = 0, clr_cnt = 0;

  always #4 clk = ~clk;

  ptr_reg_i2c_slave #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_wr(reg_wr),
    .reg_wr_msb(reg_wr_msb), .reg_wdata(reg_wdata), .alert_active(alert_active),
    .alert_high(alert_high), .alert_clr(alert_clr), .gc_reset(gc_reset), .hs_mode(hs_mode)
  );

  // register bank model on the storage side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || gc_reset) begin
      mem[0] <= 16'h1900; mem[1] <= 16'h0000; mem[2] <= 16'h4B00; mem[3] <= 16'h5000;
    end else if (reg_wr) begin
      if (reg_wr_msb) mem[reg_addr][15:8] <= reg_wdata;
      else            mem[reg_addr][7:0]  <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr)    wr_cnt++;
    if (gc_reset)  gc_cnt++;
    if (alert_clr) clr_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    msda = 1'b1; cyc(H); mscl = 1'b1; cyc(H); msda = 1'b0; cyc(H); mscl = 1'b0; cyc(H);
  endtask

  task automatic i2c_stop();
    msda = 1'b0; cyc(H); mscl = 1'b1; cyc(H); msda = 1'b1; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; cyc(H); mscl = 1'b1; cyc(H); mscl = 1'b0;
    end
    msda = 1'b1; cyc(H); mscl = 1'b1; cyc(H/2);
    ack = ~sda_line;
    cyc(H/2); mscl = 1'b0;
  endtask

  task automatic recv_byte(input logic [7:0] drive, input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      msda = drive[i]; cyc(H); mscl = 1'b1; cyc(H/2);
      b[i] = sda_line;
      cyc(H/2); mscl = 1'b0;
    end
    msda = nack; cyc(H); mscl = 1'b1; cyc(H); mscl = 1'b0; msda = 1'b1;
  endtask

  // {strap, 7-bit address, expected ack}
  localparam logic [10:0] VECS [6] = '{
    {3'd0, 7'h48, 1'b1}, {3'd0, 7'h49, 1'b0}, {3'd5, 7'h4D, 1'b1},
    {3'd5, 7'h48, 1'b0}, {3'd7, 7'h4F, 1'b1}, {3'd2, 7'h1A, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b, b2;
    cyc(5); rst_n = 1'b1; cyc(5);
    chk("R2 reset pointer", reg_addr, 2'd0);
    chk("R5 reset sda_oe", sda_oe, 1'b0);
    chk("R9 reset hs_mode", hs_mode, 1'b0);

    // R1: address match table
    for (int i = 0; i < 6; i++) begin
      strap = VECS[i][10:8];
      i2c_start(); send_byte({VECS[i][7:1], 1'b0}, a); i2c_stop();
      chk("R1 address ack", a, VECS[i][0]);
    end
    strap = 3'd0;

    // R4/R2: two-byte write to low limit
    i2c_start(); send_byte(8'h90, a); send_byte(8'h02, a);
    send_byte(8'h12, a); send_byte(8'h34, a); i2c_stop(); cyc(4);
    chk("R4 write data", mem[2], 16'h1234);
    chk("R4 write strobes", wr_cnt, 2);
    chk("R2 pointer loaded", reg_addr, 2'd2);

    // R3: read back, pointer retained; R5: NACK then extra clocks read released bus
    i2c_start(); send_byte(8'h91, a);
    recv_byte(8'hFF, 1'b0, b); recv_byte(8'hFF, 1'b1, b2);
    chk("R3 read msb", b, 8'h12);
    chk("R3 read lsb", b2, 8'h34);
    i2c_stop();
    i2c_start(); send_byte(8'h91, a); recv_byte(8'hFF, 1'b1, b);
    recv_byte(8'hFF, 1'b1, b2); i2c_stop();
    chk("R5 bus released after nack", b2, 8'hFF);

    // R4: temperature register is read-only
    i2c_start(); send_byte(8'h90, a); send_byte(8'h00, a);
    send_byte(8'hAA, a); send_byte(8'h55, a); i2c_stop(); cyc(4);
    chk("R4 no strobe on pointer 00", wr_cnt, 2);
    i2c_start(); send_byte(8'h91, a); recv_byte(8'hFF, 1'b0, b);
    recv_byte(8'hFF, 1'b1, b2); i2c_stop();
    chk("R4 temperature unchanged", {b, b2}, 16'h1900);

    // R2: pointer-only write, then separate read
    i2c_start(); send_byte(8'h90, a); i2c_stop();
    i2c_start(); send_byte(8'h90, a); send_byte(8'h03, a); i2c_stop();
    chk("R2 pointer-only write", reg_addr, 2'd3);
    i2c_start(); send_byte(8'h91, a); recv_byte(8'hFF, 1'b1, b); i2c_stop();
    chk("R2 pointer kept across transactions", b, 8'h50);

    // R11: strap latched at START
    i2c_start(); strap = 3'd7; send_byte(8'h90, a); i2c_stop();
    chk("R11 strap held after start", a, 1'b1);
    i2c_start(); send_byte(8'h90, a); i2c_stop();
    chk("R11 new strap at next start", a, 1'b0);
    strap = 3'd0;

    // R6: general call
    i2c_start(); send_byte(8'h00, a); chk("R6 general call ack", a, 1'b1);
    send_byte(8'h04, a); i2c_stop(); cyc(4);
    chk("R6 relatch no reset", gc_cnt, 0);
    chk("R6 relatch keeps pointer", reg_addr, 2'd3);
    i2c_start(); send_byte(8'h00, a); send_byte(8'h06, a); i2c_stop(); cyc(4);
    chk("R6 reset pulse", gc_cnt, 1);
    chk("R6 pointer reset", reg_addr, 2'd0);
    chk("R6 bank reset", mem[2], 16'h4B00);

    // R7/R8: alert response
    i2c_start(); send_byte(8'h19, a); i2c_stop();
    chk("R7 no ack without alert", a, 1'b0);
    alert_active = 1'b1; alert_high = 1'b1; strap = 3'd3;
    i2c_start(); send_byte(8'h19, a); chk("R7 ack with alert", a, 1'b1);
    recv_byte(8'hFF, 1'b1, b); i2c_stop(); cyc(4);
    chk("R7 reply byte", b, 8'h97);
    chk("R8 clear after win", clr_cnt, 1);
    i2c_start(); send_byte(8'h19, a); recv_byte(8'h7F, 1'b1, b);
    chk("R8 released after loss", sda_oe, 1'b0);
    i2c_stop(); cyc(4);
    chk("R8 no clear after loss", clr_cnt, 1);
    alert_active = 1'b0; strap = 3'd0;

    // R9: high-speed master code
    i2c_start(); send_byte(8'h09, a);
    chk("R9 master code not acked", a, 1'b0);
    chk("R9 hs_mode set", hs_mode, 1'b1);
    i2c_start(); send_byte(8'h91, a); recv_byte(8'hFF, 1'b1, b);
    chk("R9 hs kept over repeated start", hs_mode, 1'b1);
    i2c_stop(); cyc(4);
    chk("R9 hs cleared by stop", hs_mode, 1'b0);

    // R10: stuck-low time-out while slave drives a zero (temperature MSB bit7 = 0)
    i2c_start(); send_byte(8'h91, a); cyc(8);
    chk("R10 slave driving before timeout", sda_oe, 1'b1);
    cyc(TMO + 100);
    chk("R10 released after timeout", sda_oe, 1'b0);
    i2c_start(); send_byte(8'h91, a);
    chk("R10 answers new start", a, 1'b1);
    recv_byte(8'hFF, 1'b1, b); i2c_stop();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule